// File: doc/BRIEF.md
# Addressed Serial Display-and-Key Link Slave

This block is the host-facing port of a segment display controller with a key matrix. The host talks to it over four pins: a chip enable, a serial clock, a data input and an open-drain data output. While chip enable is low, the host clocks in an 8-bit address, least-significant bit first. Chip enable then goes high and a data frame moves in the direction that the address selects. One write address loads the segment latch and the control register in two separate 56-bit frames, which are told apart by their last two bits. One read address shifts out a 30-bit key snapshot followed by a sleep-acknowledge bit.

All pins are brought into the system clock domain by synchronizers, and every event is decided on a detected pin edge. Data is taken on rising serial-clock edges. A received frame takes effect only when chip enable falls. When chip enable is low, the data output is pulled low to show that a key read is pending. A system reset, raised at power-up or by a power-fail pulse, is held until both write frames have arrived. The reset does not touch the interface or the stored registers.

Top module: `serial_ctrl_slave`

## Requirements
- R1: The address is taken LSB first on rising serial-clock edges while chip enable is low. 42h selects a write and 43h selects a read. A frame under any other address changes no output, and the data output stays released (do_low_o = 0) while chip enable is high.
- R2: A write frame takes effect only if it had exactly 56 rising serial-clock edges and its fixed padding bits are all zero. A frame with 55 or 57 edges, or with a padding bit set, changes nothing.
- R3: Frame A ends with the bit pair 0,0 (bits 55, 56, numbered from 1 in arrival order). Bits 1..39 go to seg_o[0..38] and bits 40..45 are padding. Bits 46..54 go to sleep_sel_o[0], sleep_sel_o[1], kscan_sel_o[0], kscan_sel_o[1], port_sel_o[0..2], seg_off_o and half_bias_o, in that order.
- R4: Frame B ends with the bit pair 0,1. Bits 1..36 go to seg_o[39..74] and bits 37..54 are padding. The ending pairs 1,0 and 1,1 are rejected.
- R5: While chip enable is still high after the last bit of a frame, no latched output changes. The update appears only after chip enable falls.
- R6: In a read frame, the first bit (key_i[0]) is on the line once chip enable rises. Each falling serial-clock edge advances one bit: key_i[0..29], then SA. SA is 1 when sleep_sel_o is nonzero. A bit of value 0 drives do_low_o = 1.
- R7: While chip enable is low, do_low_o follows key_req_i, and it is forced to 0 while sys_rst_o is high.
- R8: A read started while key_req_i is low, or while in reset, shifts out all ones and raises no acknowledge. A valid read raises key_ack_o for exactly one cycle after chip enable falls.
- R9: sys_rst_o is 1 after rst and one cycle after a por_i pulse. It returns to 0 at the end of the frame that completes the set {frame A, frame B} received since that reset, in either order.
- R10: A por_i pulse leaves seg_o and the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| por_i | input | 1 | Power-fail / power-on pulse that raises the system reset |
| ce_i | input | 1 | Chip enable pin (asynchronous) |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data in pin (asynchronous) |
| key_i | input | 30 | Key snapshot from the scanner, bit 0 first on the wire |
| key_req_i | input | 1 | Scanner has a confirmed key read pending |
| do_low_o | output | 1 | 1 pulls the open-drain data line low |
| key_ack_o | output | 1 | One-cycle pulse: valid key read finished |
| seg_o | output | 75 | Segment latch |
| sleep_sel_o | output | 2 | Sleep selection field |
| kscan_sel_o | output | 2 | Scan-line / segment pin selection field |
| port_sel_o | output | 3 | General-purpose port selection field |
| seg_off_o | output | 1 | Force all segments off |
| half_bias_o | output | 1 | 1 selects half bias, 0 third bias |
| sys_rst_o | output | 1 | System reset held for the display and scanner |

## Verification
The release of the system reset and a segment-latch update come from the same chip-enable fall, so both settle in the same cycle. The bench raises the power-fail pulse and then sends the two frames in reverse order. It confirms that the reset clears exactly when the latch takes the second frame, and not after the first. The key-request signal on the data line and the read shift also share one pin. The bench holds the request high across reads made inside and outside reset, and judges each bit against the snapshot it built and the acknowledge count.

// File: rtl/sslv_pkg.sv
package sslv_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2
  } xfer_mode_e;

  // Field order follows the arrival order of the control bits (LSB first).
  typedef struct packed {
    logic       half_bias;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] kscan_sel;
    logic [1:0] sleep_sel;
  } ctrl_t;

endpackage

// File: rtl/sslv_pin_sync.sv
module sslv_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/sslv_rx.sv
module sslv_rx
  import sslv_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int unsigned WR_ADDR = 'h42,
  parameter int unsigned RD_ADDR = 'h43,
  parameter int          FRAME_W = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_lvl_i,
  input  logic               ce_rise_i,
  input  logic               ce_fall_i,
  input  logic               sck_rise_i,
  input  logic               sdi_i,
  output logic               rd_hit_o,
  output xfer_mode_e         mode_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] bits_o
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_hit;

  assign wr_hit   = (addr_q == ADDR_W'(WR_ADDR));
  assign rd_hit_o = (addr_q == ADDR_W'(RD_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_o <= MODE_IDLE;
      done_o <= 1'b0;
      bits_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (sck_rise_i && !ce_lvl_i)
        addr_q <= {sdi_i, addr_q[ADDR_W-1:1]};
      if (ce_rise_i) begin
        cnt_q  <= '0;
        mode_o <= wr_hit ? MODE_WR : (rd_hit_o ? MODE_RD : MODE_IDLE);
      end else if (sck_rise_i && ce_lvl_i && mode_o == MODE_WR) begin
        bits_o <= {sdi_i, bits_o[FRAME_W-1:1]};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
      if (ce_fall_i) begin
        done_o <= (mode_o == MODE_WR) && (cnt_q == FULL);
        mode_o <= MODE_IDLE;
      end
    end
  end

endmodule

// File: rtl/sslv_key_tx.sv
module sslv_key_tx #(
  parameter int KEY_N = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             valid_i,
  input  logic [KEY_N-1:0] key_i,
  input  logic             sa_i,
  input  logic             shift_i,
  output logic             bit_o
);

  localparam int TX_W = KEY_N + 1;

  logic [TX_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '1;
    else if (load_i)  sr_q <= valid_i ? {sa_i, key_i} : '1;
    else if (shift_i) sr_q <= {1'b1, sr_q[TX_W-1:1]};
  end

  assign bit_o = sr_q[0];

endmodule

// File: rtl/sslv_rst_track.sv
module sslv_rst_track (
  input  logic clk,
  input  logic rst,
  input  logic por_i,
  input  logic wr_a_i,
  input  logic wr_b_i,
  output logic sys_rst_o
);

  logic seen_a_q, seen_b_q;

  always_ff @(posedge clk) begin
    if (rst || por_i) begin
      seen_a_q  <= 1'b0;
      seen_b_q  <= 1'b0;
      sys_rst_o <= 1'b1;
    end else begin
      if (wr_a_i) seen_a_q <= 1'b1;
      if (wr_b_i) seen_b_q <= 1'b1;
      if ((seen_a_q || wr_a_i) && (seen_b_q || wr_b_i)) sys_rst_o <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_ctrl_slave.sv
module serial_ctrl_slave
  import sslv_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned WR_ADDR     = 'h42,
  parameter int unsigned RD_ADDR     = 'h43,
  parameter int          SEG_A       = 39,
  parameter int          SEG_B       = 36,
  parameter int          FRAME_W     = 56,
  parameter int          KEY_N       = 30,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     por_i,
  input  logic                     ce_i,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  input  logic [KEY_N-1:0]         key_i,
  input  logic                     key_req_i,
  output logic                     do_low_o,
  output logic                     key_ack_o,
  output logic [SEG_A+SEG_B-1:0]   seg_o,
  output logic [1:0]               sleep_sel_o,
  output logic [1:0]               kscan_sel_o,
  output logic [2:0]               port_sel_o,
  output logic                     seg_off_o,
  output logic                     half_bias_o,
  output logic                     sys_rst_o
);

  localparam int SEG_N    = SEG_A + SEG_B;
  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int DIR_POS  = FRAME_W - 2;
  localparam int CTRL_POS = DIR_POS - CTRL_W;

  // Pin synchronization: index 0 = ce, 1 = sclk, 2 = sdi
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  sslv_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  ({sdi_i, sclk_i, ce_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  logic               rd_hit, frame_done;
  xfer_mode_e         mode;
  logic [FRAME_W-1:0] fbits;

  sslv_rx #(
    .ADDR_W (ADDR_W), .WR_ADDR (WR_ADDR), .RD_ADDR (RD_ADDR), .FRAME_W (FRAME_W)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .ce_lvl_i   (pin_lvl[0]),
    .ce_rise_i  (pin_rise[0]),
    .ce_fall_i  (pin_fall[0]),
    .sck_rise_i (pin_rise[1]),
    .sdi_i      (pin_lvl[2]),
    .rd_hit_o   (rd_hit),
    .mode_o     (mode),
    .done_o     (frame_done),
    .bits_o     (fbits)
  );

  // Frame classification by the trailing direction pair and padding
  logic is_a, is_b, wr_a, wr_b;

  assign is_a = (fbits[FRAME_W-1:DIR_POS] == 2'b00) &&
                (fbits[CTRL_POS-1:SEG_A] == '0);
  assign is_b = (fbits[FRAME_W-1:DIR_POS] == 2'b10) &&
                (fbits[DIR_POS-1:SEG_B] == '0);
  assign wr_a = frame_done && is_a;
  assign wr_b = frame_done && is_b;

  logic [SEG_N-1:0] seg_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_a) begin
        seg_q[SEG_A-1:0] <= fbits[SEG_A-1:0];
        ctrl_q           <= ctrl_t'(fbits[CTRL_POS +: CTRL_W]);
      end
      if (wr_b)
        seg_q[SEG_N-1:SEG_A] <= fbits[SEG_B-1:0];
    end
  end

  sslv_rst_track u_rtrk (
    .clk       (clk),
    .rst       (rst),
    .por_i     (por_i),
    .wr_a_i    (wr_a),
    .wr_b_i    (wr_b),
    .sys_rst_o (sys_rst_o)
  );

  // Key readout
  logic tx_bit, rd_valid_q, rd_load, rd_end, sa;

  assign sa      = |ctrl_q.sleep_sel;
  assign rd_load = pin_rise[0] && rd_hit;
  assign rd_end  = pin_fall[0] && (mode == MODE_RD);

  sslv_key_tx #(.KEY_N(KEY_N)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (rd_load),
    .valid_i (key_req_i && !sys_rst_o),
    .key_i   (key_i),
    .sa_i    (sa),
    .shift_i (pin_fall[1] && pin_lvl[0] && (mode == MODE_RD)),
    .bit_o   (tx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      key_ack_o  <= 1'b0;
      do_low_o   <= 1'b0;
    end else begin
      if (rd_load) rd_valid_q <= key_req_i && !sys_rst_o;
      key_ack_o <= rd_end && rd_valid_q;
      if (!pin_lvl[0])            do_low_o <= key_req_i && !sys_rst_o;
      else if (mode == MODE_RD)   do_low_o <= !tx_bit;
      else                        do_low_o <= 1'b0;
    end
  end

  assign seg_o       = seg_q;
  assign sleep_sel_o = ctrl_q.sleep_sel;
  assign kscan_sel_o = ctrl_q.kscan_sel;
  assign port_sel_o  = ctrl_q.port_sel;
  assign seg_off_o   = ctrl_q.seg_off;
  assign half_bias_o = ctrl_q.half_bias;

endmodule

// File: rtl/sslv_chk.sv
module sslv_chk #(
  parameter int SEG_N = 75
) (
  input logic             clk,
  input logic             rst,
  input logic             por_i,
  input logic             ce_i,
  input logic [SEG_N-1:0] seg_o,
  input logic [8:0]       ctrl_o,
  input logic             sys_rst_o,
  input logic             key_ack_o
);

  // R5
  seg_on_ce_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(seg_o) |-> !ce_i);

  // R5
  ctrl_on_ce_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> !ce_i);

  // R9
  rst_rise_from_por_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(por_i));

  // R9
  rst_release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> !ce_i);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    key_ack_o |=> !key_ack_o);

  // R10
  por_keeps_seg_chk: assert property (@(posedge clk) disable iff (rst)
    por_i |=> $stable(seg_o));

endmodule

bind serial_ctrl_slave sslv_chk #(.SEG_N(SEG_A + SEG_B)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .por_i     (por_i),
  .ce_i      (ce_i),
  .seg_o     (seg_o),
  .ctrl_o    ({half_bias_o, seg_off_o, port_sel_o, kscan_sel_o, sleep_sel_o}),
  .sys_rst_o (sys_rst_o),
  .key_ack_o (key_ack_o)
);

// File: tb/sim_serial_ctrl_slave.sv
`timescale 1ns/1ps
module sim_serial_ctrl_slave;

  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1, por = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [29:0] key = '0;
  logic        key_req = 1'b0;
  logic        do_low, key_ack, seg_off, half_bias, sys_rst;
  logic [74:0] seg;
  logic [1:0]  sleep_sel, kscan_sel;
  logic [2:0]  port_sel;

  int checks = 0, fails = 0, ack_cnt = 0;
  bit done = 0;

  logic [74:0] exp_seg = '0;
  logic [8:0]  exp_ctrl = '0;
  logic        exp_sys = 1'b1;

  always #2 clk = ~clk;

  serial_ctrl_slave u0 (
    .clk (clk), .rst (rst), .por_i (por), .ce_i (ce), .sclk_i (sclk), .sdi_i (sdi),
    .key_i (key), .key_req_i (key_req), .do_low_o (do_low), .key_ack_o (key_ack),
    .seg_o (seg), .sleep_sel_o (sleep_sel), .kscan_sel_o (kscan_sel),
    .port_sel_o (port_sel), .seg_off_o (seg_off), .half_bias_o (half_bias),
    .sys_rst_o (sys_rst)
  );

  always @(negedge clk) if (!rst && key_ack) ack_cnt++;

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_bit(input logic b);
    sdi = b; wait_clk(HP); sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
  endtask

  task automatic open_frame(input logic [7:0] a);
    for (int i = 0; i < 8; i++) tick_bit(a[i]);
    wait_clk(HP); ce = 1'b1; wait_clk(HP);
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) tick_bit(v[i]);
    wait_clk(HP);
  endtask

  task automatic close_frame();
    ce = 1'b0; wait_clk(4*HP);
  endtask

  task automatic write_frame(input logic [7:0] a, input logic [63:0] v, input int n);
    open_frame(a); shift_bits(v, n); close_frame();
  endtask

  task automatic check_state(input string req);
    chk(req, 80'(seg), 80'(exp_seg));
    chk(req, 80'({half_bias, seg_off, port_sel, kscan_sel, sleep_sel}), 80'(exp_ctrl));
    chk(req, 80'(sys_rst), 80'(exp_sys));
  endtask

  function automatic logic [74:0] pat(input int t);
    logic [74:0] p;
    for (int i = 0; i < 75; i++) p[i] = ((i * (t + 3) + t) % 7) < 3;
    return p;
  endfunction

  function automatic logic [63:0] frm_a(input logic [74:0] p, input logic [8:0] c);
    logic [63:0] v = '0;
    v[38:0]  = p[38:0];
    v[53:45] = c;
    return v;
  endfunction

  function automatic logic [63:0] frm_b(input logic [74:0] p);
    logic [63:0] v = '0;
    v[35:0] = p[74:39];
    v[55]   = 1'b1;
    return v;
  endfunction

  task automatic read_keys(input logic [29:0] k, input logic req, input bit valid, input string tag);
    logic [30:0] got;
    logic [30:0] exp;
    int a0;
    key = k; key_req = req; a0 = ack_cnt;
    open_frame(8'h43);
    for (int i = 0; i < 31; i++) begin
      got[i] = ~do_low;
      sclk = 1'b1; wait_clk(HP); sclk = 1'b0; wait_clk(HP);
    end
    close_frame();
    exp = valid ? {(exp_ctrl[1:0] != 2'b00), k} : '1;
    chk(tag, 80'(got), 80'(exp));
    chk("R8", 80'(ack_cnt - a0), valid ? 80'd1 : 80'd0);
    key_req = 1'b0;
  endtask

  initial begin
    logic [74:0] p;
    logic [8:0]  c;
    logic [63:0] v;
    wait_clk(5); rst = 1'b0; wait_clk(4);

    // reset state
    check_state("R9");
    chk("R7", 80'(do_low), 80'd0);
    key_req = 1'b1; wait_clk(HP);
    chk("R7", 80'(do_low), 80'd0);
    key_req = 1'b0;
    read_keys(30'h1234567, 1'b1, 0, "R8");

    // first frame A: reset stays
    p = pat(0); c = 9'h0A5;
    write_frame(8'h42, frm_a(p, c), 56);
    exp_seg[38:0] = p[38:0]; exp_ctrl = c;
    check_state("R3");
    write_frame(8'h42, frm_b(p), 56);
    exp_seg[74:39] = p[74:39]; exp_sys = 1'b0;
    check_state("R9");

    // request on the line
    key_req = 1'b1; wait_clk(HP);
    chk("R7", 80'(do_low), 80'd1);
    key_req = 1'b0; wait_clk(HP);
    chk("R7", 80'(do_low), 80'd0);

    // sweep of patterns and control values
    for (int t = 1; t <= 40; t++) begin
      p = pat(t); c = 9'((t * 37 + 5) % 512);
      open_frame(8'h42); shift_bits(frm_a(p, c), 56);
      check_state("R5");
      close_frame();
      exp_seg[38:0] = p[38:0]; exp_ctrl = c;
      check_state("R3");
      write_frame(8'h42, frm_b(p), 56);
      exp_seg[74:39] = p[74:39];
      check_state("R4");
    end

    // unknown addresses
    p = ~pat(3);
    key_req = 1'b1;
    open_frame(8'h44); shift_bits(frm_a(p, 9'h1FF), 56);
    chk("R1", 80'(do_low), 80'd0);
    close_frame();
    key_req = 1'b0;
    write_frame(8'hC2, frm_a(p, 9'h1FF), 56);
    write_frame(8'h24, frm_b(p), 56);
    check_state("R1");

    // wrong counts and nonzero padding
    write_frame(8'h42, frm_a(p, 9'h1FF), 55);
    write_frame(8'h42, frm_a(p, 9'h1FF), 57);
    v = frm_a(p, 9'h1FF); v[40] = 1'b1;
    write_frame(8'h42, v, 56);
    v = frm_b(p); v[50] = 1'b1;
    write_frame(8'h42, v, 56);
    check_state("R2");

    // bad direction pairs
    v = frm_b(p); v[54] = 1'b1; v[55] = 1'b0;
    write_frame(8'h42, v, 56);
    v = frm_b(p); v[54] = 1'b1;
    write_frame(8'h42, v, 56);
    check_state("R4");

    // key reads in normal mode
    c = 9'h000; p = pat(9);
    write_frame(8'h42, frm_a(p, c), 56);
    exp_seg[38:0] = p[38:0]; exp_ctrl = c;
    for (int i = 0; i < 30; i++) read_keys(30'(1) << i, 1'b1, 1, "R6");
    // sleep selected: SA = 1
    c = 9'h002;
    write_frame(8'h42, frm_a(p, c), 56);
    exp_ctrl = c;
    read_keys(30'h2AAAAAAA, 1'b1, 1, "R6");
    read_keys(30'h15555555, 1'b1, 1, "R6");
    read_keys(30'h0, 1'b1, 1, "R6");
    // no request pending
    read_keys(30'h3FFF0001, 1'b0, 0, "R8");

    // power-fail pulse, then frames in reverse order
    por = 1'b1; wait_clk(1); por = 1'b0; wait_clk(2);
    exp_sys = 1'b1;
    check_state("R10");
    key_req = 1'b1; wait_clk(HP);
    chk("R7", 80'(do_low), 80'd0);
    key_req = 1'b0;
    p = pat(17);
    write_frame(8'h42, frm_b(p), 56);
    exp_seg[74:39] = p[74:39];
    check_state("R9");
    write_frame(8'h42, frm_a(p, 9'h155), 56);
    exp_seg[38:0] = p[38:0]; exp_ctrl = 9'h155; exp_sys = 1'b0;
    check_state("R9");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule